// File: doc/BRIEF.md
# Byte-Multiplexed Host Command Interface

This block sits between a host and the internal units of a larger design. The host has one 8-bit input port, a flag that says whether the byte on it is a command address or a data byte, and a strobe that marks each byte as valid. The top bit of a command address says whether one data byte follows. Once a command is complete, the block broadcasts it for one cycle, together with one select line for each destination group: a head unit, a tail unit, or a set of replicated body units. It then returns one 8-bit reply and a success bit to the host.

Every unit offers a response byte and an ok bit. The block gates off the units that were not selected and combines the rest by bitwise OR. Body units all receive the same command and must answer identically. If any body differs in either its byte or its ok bit, the host receives an error reply.

The controller is a four-state machine. The states are IDLE (waiting for an address byte), WAIT_DATA (an address that needs data is held), ISSUE (the command is broadcast) and REPORT (the reply is presented). Its transitions are:
- IDLE to ISSUE on a command byte with no data.
- IDLE to WAIT_DATA on a command byte that needs data.
- WAIT_DATA to ISSUE on a data byte.
- WAIT_DATA to WAIT_DATA or ISSUE on a replacing command byte.
- ISSUE to REPORT unconditionally.
- REPORT to IDLE unconditionally.

Top module: `cmdbus_host_if`

## Requirements
- R1: While reset is held, and right after it, `host_rsp_valid`, `cmd_fire` and `host_ok` are 0 and `host_rsp` is 0x00.
- R2: A strobed byte with `host_is_data`=0 is a command address. If its bit 7 is 0, `cmd_fire` is high for exactly one cycle, in the cycle after the strobe. In that cycle `cmd_addr` equals the byte and `cmd_data` is 0x00.
- R3: A command address with bit 7 set is held until a strobed data byte arrives. `cmd_fire` then rises in the cycle after the data strobe, with `cmd_data` equal to that data byte.
- R4: A strobed data byte received while no command is pending causes no fire and no reply.
- R5: A new command byte received while data is awaited replaces the pending command. The earlier command never fires.
- R6: Strobes that arrive during the fire cycle or the reply cycle are ignored.
- R7: Address bits 6:5 choose the destination: 00 head, 01 tail, 10 all bodies, 11 none. During `cmd_fire`, only the matching select line is high.
- R8: Responses from unselected units have no effect. The reply is the OR of the selected responses, and a command routed to no unit replies 0x00 with ok 0.
- R9: When all body responses and ok bits agree, a body command replies with their common byte and ok bit.
- R10: When any body differs from the others in response byte or ok bit, the reply is 0xFF with ok 0.
- R11: `host_rsp_valid` is high for exactly the cycle after `cmd_fire`. `host_rsp` and `host_ok` hold their values until the next reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_strobe | input | 1 | Marks a valid byte on host_byte |
| host_is_data | input | 1 | 1 = data byte, 0 = command address |
| host_byte | input | 8 | Shared command/data byte |
| host_rsp_valid | output | 1 | Reply valid pulse |
| host_rsp | output | 8 | Reply byte |
| host_ok | output | 1 | Reply success bit |
| cmd_fire | output | 1 | One-cycle command broadcast |
| cmd_addr | output | 8 | Broadcast command address |
| cmd_data | output | 8 | Broadcast data byte |
| sel_head | output | 1 | Head selected |
| sel_tail | output | 1 | Tail selected |
| sel_body | output | 1 | Bodies selected |
| head_rsp | input | 8 | Head response byte |
| head_ok | input | 1 | Head success bit |
| tail_rsp | input | 8 | Tail response byte |
| tail_ok | input | 1 | Tail success bit |
| body_rsp | input | 24 | Body responses, body i in bits 8i+7:8i |
| body_ok | input | 3 | Body success bits |

## Verification
The broadcast of a command without data is due one cycle after its strobe. A command with data is due one cycle after its data strobe. The reply is due one cycle after the broadcast. The bench drives on the falling edge, steps one edge at a time, and samples the fire, address, data, select and reply outputs exactly at those half-cycle points. In the ignored-stimulus cases it samples the same outputs at the cycles where a wrongly accepted byte would have appeared.

// File: rtl/cmdbus_pkg.sv
package cmdbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_DATA = 2'd1,
        ST_ISSUE     = 2'd2,
        ST_REPORT    = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        DST_HEAD = 2'd0,
        DST_TAIL = 2'd1,
        DST_BODY = 2'd2,
        DST_NONE = 2'd3
    } dest_t;

endpackage

// File: rtl/cmdbus_deframer.sv
module cmdbus_deframer
    import cmdbus_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic         is_data,
    input  logic [W-1:0] byte_in,
    output logic         fire,
    output logic         report,
    output logic [W-1:0] addr,
    output logic [W-1:0] data
);
    localparam int HAS_DATA_BIT = W - 1;

    phase_t       state, state_nx;
    logic [W-1:0] pend_addr, pend_data;
    logic         take_cmd, take_data;

    // Which strobed bytes are accepted in which state.
    always_comb begin
        take_cmd  = 1'b0;
        take_data = 1'b0;
        unique case (state)
            ST_IDLE:      take_cmd = strobe && !is_data;
            ST_WAIT_DATA: begin
                take_cmd  = strobe && !is_data;
                take_data = strobe && is_data;
            end
            ST_ISSUE:     ;
            ST_REPORT:    ;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take_cmd)
                    state_nx = byte_in[HAS_DATA_BIT] ? ST_WAIT_DATA : ST_ISSUE;
            end
            ST_WAIT_DATA: begin
                if (take_data)
                    state_nx = ST_ISSUE;
                else if (take_cmd)
                    state_nx = byte_in[HAS_DATA_BIT] ? ST_WAIT_DATA : ST_ISSUE;
            end
            ST_ISSUE:  state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            state <= state_nx;
            if (take_cmd) begin
                pend_addr <= byte_in;
                pend_data <= '0;
            end else if (take_data) begin
                pend_data <= byte_in;
            end
        end
    end

    always_comb begin
        fire   = (state == ST_ISSUE);
        report = (state == ST_REPORT);
        addr   = pend_addr;
        data   = pend_data;
    end

    // R2: a broadcast lasts exactly one cycle
    assert_fire_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R6: a fire is always preceded by an accepted strobe
    assert_fire_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(strobe));

    // R5: waiting for data only when the held address asks for it
    assert_wait_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_DATA) |-> pend_addr[HAS_DATA_BIT]);
endmodule

// File: rtl/cmdbus_router.sv
module cmdbus_router
    import cmdbus_pkg::*;
(
    input  logic       fire,
    input  logic [1:0] dest_field,
    output logic       sel_head,
    output logic       sel_tail,
    output logic       sel_body
);
    dest_t dest;

    always_comb begin
        dest     = dest_t'(dest_field);
        sel_head = 1'b0;
        sel_tail = 1'b0;
        sel_body = 1'b0;
        unique case (dest)
            DST_HEAD: sel_head = fire;
            DST_TAIL: sel_tail = fire;
            DST_BODY: sel_body = fire;
            DST_NONE: ;
        endcase
    end
endmodule

// File: rtl/cmdbus_body_agree.sv
module cmdbus_body_agree #(
    parameter int W  = 8,
    parameter int NB = 3
) (
    input  logic [NB*W-1:0] body_rsp,
    input  logic [NB-1:0]   body_ok,
    output logic [W-1:0]    agree_rsp,
    output logic            agree_ok,
    output logic            disagree
);
    logic [NB-1:0] differs;

    // Each body is compared against body 0.
    genvar gi;
    generate
        for (gi = 0; gi < NB; gi++) begin : g_cmp
            assign differs[gi] = (body_rsp[gi*W +: W] != body_rsp[W-1:0]) ||
                                 (body_ok[gi] != body_ok[0]);
        end
    endgenerate

    always_comb begin
        disagree = |differs;
        if (disagree) begin
            agree_rsp = '1;
            agree_ok  = 1'b0;
        end else begin
            agree_rsp = body_rsp[W-1:0];
            agree_ok  = body_ok[0];
        end
    end
endmodule

// File: rtl/cmdbus_host_if.sv
module cmdbus_host_if #(
    parameter int W  = 8,
    parameter int NB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_strobe,
    input  logic          host_is_data,
    input  logic [W-1:0]  host_byte,
    output logic          host_rsp_valid,
    output logic [W-1:0]  host_rsp,
    output logic          host_ok,
    output logic          cmd_fire,
    output logic [W-1:0]  cmd_addr,
    output logic [W-1:0]  cmd_data,
    output logic          sel_head,
    output logic          sel_tail,
    output logic          sel_body,
    input  logic [W-1:0]  head_rsp,
    input  logic          head_ok,
    input  logic [W-1:0]  tail_rsp,
    input  logic          tail_ok,
    input  logic [NB*W-1:0] body_rsp,
    input  logic [NB-1:0] body_ok
);
    localparam int DEST_LSB = W - 3;

    logic         report;
    logic [W-1:0] agree_rsp, merged_rsp;
    logic         agree_ok, disagree, merged_ok;
    logic [W-1:0] rsp_q;
    logic         ok_q;

    cmdbus_deframer #(.W(W)) u_deframer (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (host_strobe),
        .is_data (host_is_data),
        .byte_in (host_byte),
        .fire    (cmd_fire),
        .report  (report),
        .addr    (cmd_addr),
        .data    (cmd_data)
    );

    cmdbus_router u_router (
        .fire       (cmd_fire),
        .dest_field (cmd_addr[DEST_LSB +: 2]),
        .sel_head   (sel_head),
        .sel_tail   (sel_tail),
        .sel_body   (sel_body)
    );

    cmdbus_body_agree #(.W(W), .NB(NB)) u_agree (
        .body_rsp  (body_rsp),
        .body_ok   (body_ok),
        .agree_rsp (agree_rsp),
        .agree_ok  (agree_ok),
        .disagree  (disagree)
    );

    // Unselected units are masked to zero before the OR.
    always_comb begin
        merged_rsp = (sel_head ? head_rsp  : '0)
                   | (sel_tail ? tail_rsp  : '0)
                   | (sel_body ? agree_rsp : '0);
        merged_ok  = (sel_head && head_ok)
                   | (sel_tail && tail_ok)
                   | (sel_body && agree_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
            ok_q  <= 1'b0;
        end else if (cmd_fire) begin
            rsp_q <= merged_rsp;
            ok_q  <= merged_ok;
        end
    end

    always_comb begin
        host_rsp_valid = report;
        host_rsp       = rsp_q;
        host_ok        = ok_q;
    end

    // R11: a reply follows every broadcast in the next cycle
    assert_reply_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> host_rsp_valid);

    // R11: reply registers hold between replies
    assert_reply_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rsp_valid |-> ($stable(host_rsp) && $stable(host_ok)));

    // R10: a body disagreement never reports success
    assert_disagree_fails_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && sel_body && disagree) |=> (!host_ok && host_rsp == '1));
endmodule

// File: tb/cmdbus_host_if_test.sv
module cmdbus_host_if_test;
    localparam int W  = 8;
    localparam int NB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_strobe = 1'b0;
    logic host_is_data = 1'b0;
    logic [W-1:0] host_byte = '0;
    logic host_rsp_valid, host_ok, cmd_fire, sel_head, sel_tail, sel_body;
    logic [W-1:0] host_rsp, cmd_addr, cmd_data;
    logic [W-1:0] head_rsp, tail_rsp;
    logic head_ok, tail_ok;
    logic [NB*W-1:0] body_rsp;
    logic [NB-1:0] body_ok;

    int flt_idx = -1;
    int okflt_idx = -1;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    // Unit models: they answer whether or not they are selected.
    assign head_rsp = cmd_addr ^ cmd_data ^ 8'h11;
    assign head_ok  = 1'b1;
    assign tail_rsp = cmd_addr + cmd_data;
    assign tail_ok  = cmd_addr[0];
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            body_rsp[i*W +: W] = (cmd_addr ^ cmd_data) ^ ((flt_idx == i) ? 8'h01 : 8'h00);
            body_ok[i]         = (okflt_idx != i);
        end
    end

    cmdbus_host_if #(.W(W), .NB(NB)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] expect_reply(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] dd;
        dd = a[7] ? d : 8'h00;
        case (a[6:5])
            2'd0: return {1'b1, a ^ dd ^ 8'h11};
            2'd1: return {a[0], a + dd};
            2'd2: begin
                if (flt_idx >= 0 || okflt_idx >= 0) return {1'b0, 8'hFF};
                return {1'b1, a ^ dd};
            end
            default: return {1'b0, 8'h00};
        endcase
    endfunction

    // Full transaction; called on a falling edge.
    task automatic do_cmd(input logic [7:0] a, input logic [7:0] d, input string req);
        logic [8:0] e;
        logic [7:0] dd;
        dd = a[7] ? d : 8'h00;
        host_strobe = 1'b1; host_is_data = 1'b0; host_byte = a;
        @(negedge clk);
        if (a[7]) begin
            chk({req, " R3 no fire before data"}, cmd_fire, 0);
            host_strobe = 1'b1; host_is_data = 1'b1; host_byte = d;
            @(negedge clk);
        end
        host_strobe = 1'b0;
        chk({req, " R2 fire"}, cmd_fire, 1);
        chk({req, " R2 addr"}, cmd_addr, a);
        chk({req, " R3 data"}, cmd_data, dd);
        chk({req, " R7 selects"}, {sel_head, sel_tail, sel_body},
            {a[6:5] == 2'd0, a[6:5] == 2'd1, a[6:5] == 2'd2});
        @(negedge clk);
        e = expect_reply(a, d);
        chk({req, " R11 valid"}, host_rsp_valid, 1);
        chk({req, " R8 reply"}, host_rsp, e[7:0]);
        chk({req, " R8 ok"}, host_ok, e[8]);
        @(negedge clk);
        chk({req, " R11 valid drops"}, host_rsp_valid, 0);
        chk({req, " R11 hold"}, {host_ok, host_rsp}, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", host_rsp_valid, 0);
        chk("R1 reset fire", cmd_fire, 0);
        chk("R1 reset rsp", {host_ok, host_rsp}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {host_rsp_valid, cmd_fire, host_ok, host_rsp}, 0);

        // Sweep of every address; R7 R8 R9 over all routes
        for (int a = 0; a < 256; a++)
            do_cmd(8'(a), 8'(a * 7 + 3), "sweep");

        // R10: byte mismatch on each body
        for (int j = 0; j < NB; j++) begin
            flt_idx = j;
            do_cmd(8'h40, 8'h00, "R10 byte mismatch");
            do_cmd(8'hC5, 8'h3C, "R10 byte mismatch data");
        end
        flt_idx = -1;
        okflt_idx = 2;
        do_cmd(8'h41, 8'h00, "R10 ok mismatch");
        okflt_idx = -1;
        do_cmd(8'h41, 8'h00, "R9 agree again");

        // R4: stray data byte in idle
        host_strobe = 1'b1; host_is_data = 1'b1; host_byte = 8'h55;
        @(negedge clk);
        host_strobe = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R4 stray fire", cmd_fire, 0);
            chk("R4 stray valid", host_rsp_valid, 0);
            @(negedge clk);
        end

        // R5: replacement of pending command
        host_strobe = 1'b1; host_is_data = 1'b0; host_byte = 8'h85;
        @(negedge clk);
        chk("R5 waiting", cmd_fire, 0);
        host_byte = 8'h21;
        @(negedge clk);
        host_strobe = 1'b0;
        chk("R5 fire", cmd_fire, 1);
        chk("R5 addr", cmd_addr, 8'h21);
        chk("R5 data", cmd_data, 8'h00);
        @(negedge clk);
        chk("R5 reply", {host_rsp_valid, host_ok, host_rsp}, {2'b11, 8'h21});
        @(negedge clk);

        // R6: strobes in fire and reply cycles ignored
        host_strobe = 1'b1; host_is_data = 1'b0; host_byte = 8'h01;
        @(negedge clk);
        chk("R6 fire", cmd_fire, 1);
        host_byte = 8'h22;
        @(negedge clk);
        chk("R6 reply", {host_rsp_valid, host_ok, host_rsp}, {2'b11, 8'h10});
        host_byte = 8'h23;
        @(negedge clk);
        host_strobe = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R6 no extra fire", cmd_fire, 0);
            chk("R6 no extra reply", host_rsp_valid, 0);
            @(negedge clk);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule